// File: doc/BRIEF.md
# Stage-Grouped Pipeline Control

This block sits beside a five-stage in-order datapath (fetch, decode, execute, memory, writeback). It decodes the opcode of the instruction held in the fetch/decode register once. It then splits the resulting control bits into three bundles: one used in execute, one used in memory access and one used at register writeback. Each bundle rides down the pipeline registers together with its instruction. A stage acts only on its own bundle and hands every later bundle to the next register unchanged. Because a new instruction enters every cycle, each pipeline register holds controls that belong to a different instruction.

The destination register number moves along with the instruction. The execute stage picks it from the instruction's own rt or rd field and carries it through to writeback. It is never taken from whatever instruction currently sits in decode. The memory stage also forms the branch-taken select from its branch bit and the ALU zero flag that the datapath supplies.

Top module: `ctrl_pipe`

## Requirements
- R1: Opcode 0x00 (instr[31:26]) yields execute bundle alu_src=0, alu_op=2'b10, reg_dst=1; memory bundle all zero; writeback bundle reg_write=1, mem_to_reg=0.
- R2: Opcode 0x23 yields alu_src=1, alu_op=2'b00, reg_dst=0; mem_read=1, mem_write=0, branch=0; reg_write=1, mem_to_reg=1.
- R3: Opcode 0x2B yields alu_src=1, alu_op=2'b00, reg_dst=0; mem_write=1, the other memory bits 0; reg_write=0, mem_to_reg=0.
- R4: Opcode 0x04 yields alu_src=0, alu_op=2'b01, reg_dst=0; branch=1, the other memory bits 0; both writeback bits 0.
- R5: Any other opcode yields every control bit zero, so it passes through as a bubble.
- R6: An instruction presented at `instr` before rising edge k shows its execute bundle after edge k, its memory bundle after edge k+1 and its writeback bundle after edge k+2. Back-to-back instructions do not disturb each other.
- R7: The destination number is instr[15:11] (rd) when that instruction's reg_dst is 1, and instr[20:16] (rt) otherwise. It appears on `wb_dst` in the same cycle as that instruction's writeback bundle.
- R8: `pc_src` is 1 exactly when the memory-stage branch bit is 1 and `alu_zero` is 1. It responds to `alu_zero` within the same cycle.
- R9: A synchronous active-high reset clears every control bit and the destination number in all three pipeline registers to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word from the fetch/decode register |
| alu_zero | input | 1 | Zero flag of the ALU result held in the memory stage |
| ex_alu_src | output | 1 | Execute: second ALU operand is the immediate |
| ex_alu_op | output | 2 | Execute: ALU operation class |
| ex_reg_dst | output | 1 | Execute: destination is rd rather than rt |
| mem_read | output | 1 | Memory: data read |
| mem_write | output | 1 | Memory: data write |
| mem_branch | output | 1 | Memory: instruction is a conditional branch |
| pc_src | output | 1 | Memory: branch taken, redirect the PC |
| wb_reg_write | output | 1 | Writeback: register file write enable |
| wb_mem_to_reg | output | 1 | Writeback: write data comes from memory |
| wb_dst | output | 5 | Writeback: register number to write |

## Verification
The bench streams a run of mixed instructions back to back. A design that took the destination or a later bundle from the instruction now in decode, rather than from the one that owns it, would show a neighbour's values in the memory or writeback stage. A load whose rd field differs from its rt exposes a destination selected by the wrong field. An all-ones word and an unlisted opcode check that unknown opcodes do not leak a write enable. Directed steps toggle the zero flag while a branch, and then a non-branch, occupies the memory stage. They also assert reset with the pipeline full, which catches a register left holding a stale write enable.

// File: rtl/ctrl_pipe.sv
module ctrl_pipe #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      instr,
  input  logic             alu_zero,
  output logic             ex_alu_src,
  output logic [1:0]       ex_alu_op,
  output logic             ex_reg_dst,
  output logic             mem_read,
  output logic             mem_write,
  output logic             mem_branch,
  output logic             pc_src,
  output logic             wb_reg_write,
  output logic             wb_mem_to_reg,
  output logic [REG_W-1:0] wb_dst
);

  localparam logic [5:0] OP_ALU   = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  wire [5:0]       op    = instr[31:26];
  wire [REG_W-1:0] rt_id = instr[16 +: REG_W];
  wire [REG_W-1:0] rd_id = instr[11 +: REG_W];
  wire unused_fields = ^{instr[25:21], instr[10:0]};

  logic       d_alu_src, d_reg_dst, d_mrd, d_mwr, d_br, d_rw, d_m2r;
  logic [1:0] d_alu_op;

  always_comb begin
    {d_alu_src, d_alu_op, d_reg_dst, d_mrd, d_mwr, d_br, d_rw, d_m2r} = '0;
    case (op)
      OP_ALU:   begin d_reg_dst = 1'b1; d_rw = 1'b1; d_alu_op = 2'b10; end
      OP_LOAD:  begin d_alu_src = 1'b1; d_mrd = 1'b1; d_m2r = 1'b1; d_rw = 1'b1; end
      OP_STORE: begin d_alu_src = 1'b1; d_mwr = 1'b1; end
      OP_BEQ:   begin d_br = 1'b1; d_alu_op = 2'b01; end
      default:  ;
    endcase
  end

  // decode/execute register: all three bundles plus both candidate numbers
  logic             x_mrd, x_mwr, x_br, x_rw, x_m2r;
  logic [REG_W-1:0] x_rt, x_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      {ex_alu_src, ex_alu_op, ex_reg_dst} <= '0;
      {x_mrd, x_mwr, x_br, x_rw, x_m2r}  <= '0;
      x_rt <= '0;
      x_rd <= '0;
    end else begin
      {ex_alu_src, ex_alu_op, ex_reg_dst} <= {d_alu_src, d_alu_op, d_reg_dst};
      {x_mrd, x_mwr, x_br, x_rw, x_m2r}  <= {d_mrd, d_mwr, d_br, d_rw, d_m2r};
      x_rt <= rt_id;
      x_rd <= rd_id;
    end
  end

  wire [REG_W-1:0] x_dst = ex_reg_dst ? x_rd : x_rt;

  // execute/memory register: memory and writeback bundles
  logic             m_rw, m_m2r;
  logic [REG_W-1:0] m_dst;

  always_ff @(posedge clk) begin
    if (rst) begin
      {mem_read, mem_write, mem_branch, m_rw, m_m2r} <= '0;
      m_dst <= '0;
    end else begin
      {mem_read, mem_write, mem_branch, m_rw, m_m2r} <= {x_mrd, x_mwr, x_br, x_rw, x_m2r};
      m_dst <= x_dst;
    end
  end

  assign pc_src = mem_branch & alu_zero;

  // memory/writeback register: writeback bundle only
  always_ff @(posedge clk) begin
    if (rst) begin
      {wb_reg_write, wb_mem_to_reg} <= '0;
      wb_dst <= '0;
    end else begin
      {wb_reg_write, wb_mem_to_reg} <= {m_rw, m_m2r};
      wb_dst <= m_dst;
    end
  end

  p_mem_follows_ex_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> {mem_read, mem_write, mem_branch} == $past({x_mrd, x_mwr, x_br}));

  p_wb_follows_mem_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> {wb_reg_write, wb_mem_to_reg, wb_dst} == $past({m_rw, m_m2r, m_dst}));

  p_dst_select_r7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> m_dst == ($past(ex_reg_dst) ? $past(x_rd) : $past(x_rt)));

  p_load_writes_r2: assert property (@(posedge clk) disable iff (rst)
    mem_read |=> wb_reg_write && wb_mem_to_reg);

  p_store_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    mem_write |=> !wb_reg_write);

  p_no_taken_without_branch_r8: assert property (@(posedge clk) disable iff (rst)
    !mem_branch |-> !pc_src);

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> !ex_alu_src && ex_alu_op == 2'b00 && !ex_reg_dst && !mem_read &&
            !mem_write && !mem_branch && !wb_reg_write && !wb_mem_to_reg && wb_dst == '0);

endmodule

// File: tb/ctrl_pipe_tb.sv
module ctrl_pipe_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'hFC00_0000;
  logic        alu_zero = 1'b0;
  logic        ex_alu_src, ex_reg_dst, mem_read, mem_write, mem_branch, pc_src;
  logic        wb_reg_write, wb_mem_to_reg;
  logic [1:0]  ex_alu_op;
  logic [4:0]  wb_dst;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ctrl_pipe dut_i (
    .clk(clk), .rst(rst), .instr(instr), .alu_zero(alu_zero),
    .ex_alu_src(ex_alu_src), .ex_alu_op(ex_alu_op), .ex_reg_dst(ex_reg_dst),
    .mem_read(mem_read), .mem_write(mem_write), .mem_branch(mem_branch),
    .pc_src(pc_src), .wb_reg_write(wb_reg_write), .wb_mem_to_reg(wb_mem_to_reg),
    .wb_dst(wb_dst)
  );

  // [45:14] instr, [13] alu_src, [12:11] alu_op, [10] reg_dst,
  // [9] mem_read, [8] mem_write, [7] branch, [6] reg_write, [5] mem_to_reg, [4:0] dst
  localparam int NV = 8;
  localparam logic [45:0] VEC [NV] = '{
    {6'h00, 5'd1, 5'd2,  5'd3,  11'h0,  1'b0, 2'b10, 1'b1, 3'b000, 2'b10, 5'd3},
    {6'h23, 5'd4, 5'd5,  16'h1234,      1'b1, 2'b00, 1'b0, 3'b100, 2'b11, 5'd5},
    {6'h2B, 5'd4, 5'd6,  16'h4C00,      1'b1, 2'b00, 1'b0, 3'b010, 2'b00, 5'd6},
    {6'h04, 5'd1, 5'd7,  16'h0808,      1'b0, 2'b01, 1'b0, 3'b001, 2'b00, 5'd7},
    {6'h08, 5'd1, 5'd9,  5'd12, 11'h0,  1'b0, 2'b00, 1'b0, 3'b000, 2'b00, 5'd9},
    {6'h00, 5'd3, 5'd0,  5'd31, 11'h0,  1'b0, 2'b10, 1'b1, 3'b000, 2'b10, 5'd31},
    {6'h23, 5'd0, 5'd31, 16'h0000,      1'b1, 2'b00, 1'b0, 3'b100, 2'b11, 5'd31},
    {32'hFFFF_FFFF,                     1'b0, 2'b00, 1'b0, 3'b000, 2'b00, 5'd31}
  };
  localparam logic [31:0] BUBBLE = 32'hFC00_0000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag(input logic [5:0] op);
    case (op)
      6'h00:   return "R1";
      6'h23:   return "R2";
      6'h2B:   return "R3";
      6'h04:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check_zero(input string req);
    chk(req, {24'd0, ex_alu_src, ex_alu_op, ex_reg_dst, mem_read, mem_write, mem_branch, 1'b0}, 32'd0);
    chk(req, {25'd0, wb_reg_write, wb_mem_to_reg, wb_dst}, 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_zero("R9 initial");
    rst = 1'b0;

    // stream: entry i enters at the same negedge as entry i-1 reaches execute
    instr = VEC[0][45:14];
    for (int i = 0; i < NV + 2; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i < NV)
        chk({tag(VEC[i][45:40]), " ex R6"}, {28'd0, ex_alu_src, ex_alu_op, ex_reg_dst},
            {28'd0, VEC[i][13:10]});
      if (i >= 1 && i - 1 < NV)
        chk({tag(VEC[i-1][45:40]), " mem R6"}, {29'd0, mem_read, mem_write, mem_branch},
            {29'd0, VEC[i-1][9:7]});
      if (i >= 2)
        chk({tag(VEC[i-2][45:40]), " wb R7"}, {25'd0, wb_reg_write, wb_mem_to_reg, wb_dst},
            {25'd0, VEC[i-2][6:0]});
      instr = (i + 1 < NV) ? VEC[i+1][45:14] : BUBBLE;
    end

    // R8: branch in memory stage, zero flag toggled within the cycle
    instr = {6'h04, 5'd2, 5'd3, 16'h0010};
    @(posedge clk); @(negedge clk);
    instr = BUBBLE;
    @(posedge clk); @(negedge clk);
    alu_zero = 1'b0; #1;
    chk("R8 branch not taken", {31'd0, pc_src}, 32'd0);
    alu_zero = 1'b1; #1;
    chk("R8 branch taken", {31'd0, pc_src}, 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R8 no branch zero high", {31'd0, pc_src}, 32'd0);
    alu_zero = 1'b0;

    // R9: reset with the pipeline full of writes
    instr = {6'h00, 5'd1, 5'd2, 5'd17, 11'h0};
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk("R1 full pipe wb", {25'd0, wb_reg_write, wb_mem_to_reg, wb_dst}, {25'd0, 2'b10, 5'd17});
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check_zero("R9 mid-run");
    rst = 1'b0;
    instr = BUBBLE;
    @(posedge clk); @(negedge clk);
    chk("R5 bubble after reset", {31'd0, wb_reg_write}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule